// File: doc/BRIEF.md
# Grouped Pin Interrupt Summary with End-of-Interrupt Re-arm

The block gathers pending-request lines from a bank of pins and folds them into a summary vector. Each summary bit stands for a group of four neighbouring pins. Software reads the vector through two 32-bit status words. From that read it learns which groups need service, so it does not have to poll every pin register.

A single parent interrupt goes to the upstream controller. This output does not simply follow the OR of the requests. It latches high once any group is pending. It then holds until software writes the end-of-interrupt bit in the master control word. That write re-arms the block. If requests are still pending at that point, the parent interrupt rises again one cycle later. A handler that misses a late request therefore still gets a fresh edge.

Access is through a simple single-cycle register port: address, write enable and write data, with combinational read data.

Top module: `irq_summary_eoi`

## Requirements
- R1: Summary bit n is 1 exactly when at least one of request lines 4n, 4n+1, 4n+2, 4n+3 is 1. With the default of 184 pins there are 46 summary bits.
- R2: A read at byte offset 0x2f8 returns summary bits 0 to 31 in data bits 0 to 31.
- R3: A read at byte offset 0x2fc returns summary bits 32 to 45 in data bits 0 to 13. Data bits 14 to 31 read 0.
- R4: The status words are read-only. A write to 0x2f8 or 0x2fc leaves both read values and the interrupt output unchanged.
- R5: Suppose the parent interrupt is low and no end-of-interrupt write is taking place. If any summary bit is 1 at a rising clock edge, irq_o is 1 after that edge. irq_o never rises while all requests are 0.
- R6: Once irq_o is 1, it stays 1 when all requests drop, until an end-of-interrupt write.
- R7: A write to offset 0xfc with data bit 29 set is an end-of-interrupt. It drives irq_o to 0 after that edge. If any request is still 1, irq_o returns to 1 after the following edge.
- R8: The master word at 0xfc stores every written bit except bit 29. Bit 29 always reads 0.
- R9: After reset, irq_o is 0 and the master word reads 0.
- R10: A read at any offset other than 0x2f8, 0x2fc and 0xfc returns 0.
- R11: A master write with bit 29 clear does not change irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_PINS (184) | Per-pin pending-request lines |
| addr_i | input | ADDR_W (12) | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Combinational read data for addr_i |
| irq_o | output | 1 | Parent interrupt |

## Verification
The hardest case to reach from the ports is an end-of-interrupt that arrives while a request is still pending. For one cycle the output must drop, and on the next cycle it must rise again. A bench that clears the requests before acknowledging never sees this. The stimulus therefore holds a request through the end-of-interrupt write and samples irq_o on both of the following cycles.

Every pin is driven alone in a sweep. This proves that each summary bit maps to its own four lines and to the right status word. It also covers the boundary between bit 31 and bit 32 and the last group.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;
  localparam int unsigned OFS_W       = 12;
  localparam logic [OFS_W-1:0] STAT_LO_OFS = 12'h2f8;
  localparam logic [OFS_W-1:0] STAT_HI_OFS = 12'h2fc;
  localparam logic [OFS_W-1:0] CTRL_OFS    = 12'h0fc;
  localparam int unsigned EOI_BIT     = 29;
endpackage

// File: rtl/irq_group_or.sv
module irq_group_or #(
  parameter int unsigned NUM_PINS   = 184,
  parameter int unsigned GROUP_SIZE = 4,
  localparam int unsigned NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
  input  logic [NUM_PINS-1:0]   req_i,
  output logic [NUM_GROUPS-1:0] summary_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign summary_o[g] = |req_i[g*GROUP_SIZE +: GROUP_SIZE];
  end
endmodule

// File: rtl/irq_parent_ctrl.sv
module irq_parent_ctrl
  import irq_sum_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              any_req_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << EOI_BIT);

  logic ctrl_wr, eoi_wr, irq_q;
  logic [DATA_W-1:0] ctrl_q;

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(CTRL_OFS));
  assign eoi_wr  = ctrl_wr && wdata_i[EOI_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata_i & KEEP_MASK;
  end

  // not asserted == armed; EOI drops the line and re-arms in one step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else if (eoi_wr) irq_q <= 1'b0;
    else if (any_req_i) irq_q <= 1'b1;
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;

  assert_irq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !eoi_wr) |=> irq_q);
  assert_irq_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && any_req_i && !eoi_wr) |=> irq_q);
  assert_eoi_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr |=> !irq_q);
  assert_plain_wr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !eoi_wr && !any_req_i) |=> (irq_q == $past(irq_q)));
endmodule

// File: rtl/irq_summary_eoi.sv
module irq_summary_eoi
  import irq_sum_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 184,
  parameter int unsigned GROUP_SIZE = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] req_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  localparam int unsigned NUM_GROUPS = NUM_PINS / GROUP_SIZE;
  localparam int unsigned PAD_W      = 2 * DATA_W;

  logic [NUM_GROUPS-1:0] summary;
  logic [PAD_W-1:0]      sum_pad;
  logic [DATA_W-1:0]     ctrl;
  logic                  any_req;

  irq_group_or #(.NUM_PINS(NUM_PINS), .GROUP_SIZE(GROUP_SIZE)) u_grp (
    .req_i     (req_i),
    .summary_o (summary)
  );

  assign any_req = |summary;
  assign sum_pad = PAD_W'(summary);

  irq_parent_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .any_req_i (any_req),
    .ctrl_o    (ctrl),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_W'(STAT_LO_OFS): rdata_o = sum_pad[DATA_W-1:0];
      ADDR_W'(STAT_HI_OFS): rdata_o = sum_pad[PAD_W-1:DATA_W];
      ADDR_W'(CTRL_OFS):    rdata_o = ctrl;
      default:              rdata_o = '0;
    endcase
  end

  assert_any_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|summary) == (|req_i));
  assert_no_spurious_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !(|req_i)) |=> !irq_o);
  assert_eoi_reads_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(CTRL_OFS)) |-> !rdata_o[EOI_BIT]);
endmodule

// File: tb/irq_summary_eoi_test.sv
`timescale 1ns/1ps
module irq_summary_eoi_test;
  localparam int NP = 184;
  localparam logic [11:0] A_LO = 12'h2f8, A_HI = 12'h2fc, A_CT = 12'h0fc;
  localparam logic [31:0] EOI = 32'h2000_0000;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [NP-1:0] req = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_summary_eoi uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 irq", 32'(irq), 0);
    rd(A_CT, d); chk("R9 master", d, 0);
    rst_n = 1;
    @(negedge clk);

    // R8 read/write storage, EOI bit reads 0
    wr(A_CT, 32'hA5A5_5A5A | EOI);
    rd(A_CT, d); chk("R8 readback", d, 32'h85A5_5A5A);
    wr(A_CT, 32'h1234_0F0F);
    rd(A_CT, d); chk("R8 readback2", d, 32'h1234_0F0F);

    // R10 unmapped
    rd(12'h100, d); chk("R10 unmapped", d, 0);
    rd(12'h2f4, d); chk("R10 unmapped2", d, 0);

    // R4 status read-only
    wr(A_LO, 32'hFFFF_FFFF); wr(A_HI, 32'hFFFF_FFFF);
    rd(A_LO, d); chk("R4 lo", d, 0);
    rd(A_HI, d); chk("R4 hi", d, 0);
    chk("R4 irq", 32'(irq), 0);

    // sweep every pin alone
    for (int p = 0; p < NP; p++) begin
      int g;
      logic [31:0] elo, ehi;
      g = p / 4;
      elo = (g < 32) ? (32'd1 << g) : 32'd0;
      ehi = (g >= 32) ? (32'd1 << (g - 32)) : 32'd0;
      @(negedge clk);
      chk("R5 idle low", 32'(irq), 0);
      req = '0; req[p] = 1'b1;
      rd(A_LO, d); chk("R1 R2 lo", d, elo);
      rd(A_HI, d); chk("R1 R3 hi", d, ehi);
      @(negedge clk);
      chk("R5 rise", 32'(irq), 1);
      req = '0;
      @(negedge clk);
      chk("R6 hold", 32'(irq), 1);
      wr(A_CT, EOI);
      chk("R7 eoi drop", 32'(irq), 0);
    end

    // all groups pending
    req = '1;
    rd(A_LO, d); chk("R2 all lo", d, 32'hFFFF_FFFF);
    rd(A_HI, d); chk("R3 all hi", d, 32'h0000_3FFF);
    @(negedge clk);
    chk("R5 all rise", 32'(irq), 1);

    // R11 plain master write keeps irq
    req = '0;
    wr(A_CT, 32'h0000_00FF);
    chk("R11 irq kept", 32'(irq), 1);
    @(negedge clk);
    chk("R11 irq kept2", 32'(irq), 1);

    // R7 EOI with request still pending: drop then re-assert
    req[181] = 1'b1;
    rd(A_HI, d); chk("R3 last group", d, 32'h0000_2000);
    wr(A_CT, EOI);
    chk("R7 pending drop", 32'(irq), 0);
    @(negedge clk);
    chk("R7 pending reassert", 32'(irq), 1);
    req = '0;
    @(negedge clk);
    chk("R6 hold after reassert", 32'(irq), 1);
    wr(A_CT, EOI);
    chk("R7 final drop", 32'(irq), 0);
    rd(A_CT, d); chk("R8 eoi reads 0", d, 0);
    @(negedge clk);
    chk("R5 stays low", 32'(irq), 0);

    // R4 status write while pending does not disturb
    req[3] = 1'b1;
    @(negedge clk);
    wr(A_LO, 32'h0);
    rd(A_LO, d); chk("R4 lo pending", d, 32'h1);
    chk("R4 irq pending", 32'(irq), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule